// File: doc/BRIEF.md
# Power-Mode and Clock-Source Controller

This block selects the operating power mode of a small microcontroller and drives the clock-source controls that go with each mode. Software writes a small mode register. The core raises a one-cycle pulse when it executes its halt instruction, and the interrupt logic raises a wake event to leave the halted state. From the register contents and the halted state, the block decides four things: whether the 32768 Hz oscillator runs, whether the frequency up-converter that makes the fast clock runs, whether the CPU runs from the fast or the slow clock, and whether the CPU clock is gated off.

The analog oscillators, the frequency up-converter and the glitch-free clock multiplexer are outside the block. They appear as enable outputs and ready inputs. The watchdog oscillator enable comes directly from a static configuration input. The block also reports the resolved mode on a two-bit output.

Top module: `pwr_clk_ctrl`

## Requirements
- R1: After reset, the register reads 0 and the block is in green mode (mode_state = 0). The slow oscillator is enabled, the up-converter is disabled, and the CPU runs from the slow clock.
- R2: The register bits are defined as follows: bit 2 is the clock-select bit, bit 1 is the halt-depth bit, and bit 0 is the up-converter enable. A write stores these three bits. Bits 7 to 3 always read back as 0.
- R3: Normal mode (mode_state = 1) applies when the block is not halted and both bit 2 and bit 0 are 1. In normal mode both oscillators are enabled, and the CPU clock runs from the fast clock (cpu_clk_fast = 1) once hf_rdy is high.
- R4: cpu_clk_fast is 1 only when bit 2 = 1, bit 0 = 1, the block is not halted, and hf_rdy = 1. In every other case the CPU stays on the slow clock.
- R5: Green mode (mode_state = 0) applies when the block is not halted and normal mode does not apply. In green mode the slow oscillator is enabled, the CPU runs from the slow clock, and upconv_en equals bit 0.
- R6: A halt pulse with bit 1 = 0 enters sleep mode (mode_state = 2) on the next cycle. In sleep mode the slow oscillator stays on, the up-converter is off, and the CPU clock is stopped.
- R7: A halt pulse with bit 1 = 1 enters idle mode (mode_state = 3) on the next cycle. In idle mode both oscillators are off and the CPU clock is stopped.
- R8: A wake event while halted leaves the halted state on the next cycle. Leaving sleep restarts the CPU clock at once.
- R9: Leaving idle clears bit 1 to 0. After an idle exit, the CPU clock stays stopped until a cycle after the wake in which lf_osc_rdy = 1.
- R10: wdt_osc_en equals wdt_cfg_en in every mode, including sleep and idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr_en | input | 1 | Mode register write strobe |
| reg_wr_data | input | 8 | Mode register write data |
| reg_rd_data | output | 8 | Mode register read data |
| halt_pulse | input | 1 | One-cycle pulse when the halt instruction executes |
| wake_evt | input | 1 | Wake-up event |
| wdt_cfg_en | input | 1 | Static watchdog oscillator configuration |
| lf_osc_rdy | input | 1 | Slow oscillator ready |
| hf_rdy | input | 1 | Fast clock ready from the up-converter |
| lf_osc_en | output | 1 | Slow oscillator enable |
| upconv_en | output | 1 | Up-converter enable |
| cpu_clk_fast | output | 1 | CPU clock select, 1 = fast clock |
| cpu_clk_run | output | 1 | CPU clock gate, 1 = running |
| wdt_osc_en | output | 1 | Watchdog oscillator enable |
| mode_state | output | 2 | Resolved mode: 0 green, 1 normal, 2 sleep, 3 idle |

## Verification
The assertions take for granted that software does not write the register in the same cycle as a wake event from idle, so that the hardware clear of bit 1 can be seen on the following cycle. They also assume that wdt_cfg_en does not change while the block runs. The stimulus keeps every register write in a separate cycle from halt and wake events, and holds the configuration input steady within each scenario.

// File: rtl/pcc_pkg.sv
`timescale 1ns/1ps
package pcc_pkg;
   typedef enum logic [1:0] {
      PM_GREEN  = 2'd0,
      PM_NORMAL = 2'd1,
      PM_SLEEP  = 2'd2,
      PM_IDLE   = 2'd3
   } pmode_t;

   typedef struct packed {
      logic sel_fast;   // bit 2
      logic deep;       // bit 1
      logic up_en;      // bit 0
   } mode_bits_t;

   localparam int FIELD_W = 3;
endpackage

// File: rtl/pcc_mode_reg.sv
`timescale 1ns/1ps
module pcc_mode_reg
   import pcc_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_en,
   input  logic [REG_W-1:0] wr_data,
   input  logic             clr_deep,
   output mode_bits_t       bits,
   output logic [REG_W-1:0] rd_data
);
   localparam int PAD_W = REG_W - FIELD_W;

   initial begin
      assert (REG_W >= FIELD_W) else $error("REG_W too small for mode field");
   end

   mode_bits_t bits_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         bits_q <= '0;
      end else if (wr_en) begin
         bits_q <= mode_bits_t'(wr_data[FIELD_W-1:0]);
      end else if (clr_deep) begin
         bits_q.deep <= 1'b0;
      end
   end

   assign bits = bits_q;

   generate
      if (PAD_W > 0) begin : g_pad
         assign rd_data = {{PAD_W{1'b0}}, bits_q};
      end else begin : g_nopad
         assign rd_data = bits_q;
      end
   endgenerate
endmodule

// File: rtl/pcc_halt_track.sv
`timescale 1ns/1ps
module pcc_halt_track (
   input  logic clk,
   input  logic rst_n,
   input  logic halt_pulse,
   input  logic wake_evt,
   input  logic deep_sel,
   input  logic lf_rdy,
   output logic halted,
   output logic idle_exit,
   output logic lf_wait
);
   logic halted_q, wait_q;

   assign idle_exit = halted_q & wake_evt & deep_sel;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         halted_q <= 1'b0;
         wait_q   <= 1'b0;
      end else begin
         if (halted_q && wake_evt)
            halted_q <= 1'b0;
         else if (halt_pulse)
            halted_q <= 1'b1;

         if (idle_exit)
            wait_q <= 1'b1;
         else if (wait_q && lf_rdy)
            wait_q <= 1'b0;
      end
   end

   assign halted  = halted_q;
   assign lf_wait = wait_q;
endmodule

// File: rtl/pcc_mode_decode.sv
`timescale 1ns/1ps
module pcc_mode_decode
   import pcc_pkg::*;
(
   input  mode_bits_t bits,
   input  logic       halted,
   input  logic       lf_wait,
   input  logic       hf_rdy,
   output pmode_t     mode,
   output logic       lf_en,
   output logic       up_en,
   output logic       sel_fast,
   output logic       clk_run
);
   always_comb begin
      if (halted)
         mode = bits.deep ? PM_IDLE : PM_SLEEP;
      else if (bits.sel_fast && bits.up_en)
         mode = PM_NORMAL;
      else
         mode = PM_GREEN;
   end

   assign lf_en    = (mode != PM_IDLE);
   assign up_en    = !halted && bits.up_en;
   assign sel_fast = (mode == PM_NORMAL) && hf_rdy;
   assign clk_run  = !halted && !lf_wait;
endmodule

// File: rtl/pwr_clk_ctrl.sv
`timescale 1ns/1ps
module pwr_clk_ctrl
   import pcc_pkg::*;
#(
   parameter int REG_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr_en,
   input  logic [REG_W-1:0] reg_wr_data,
   output logic [REG_W-1:0] reg_rd_data,
   input  logic             halt_pulse,
   input  logic             wake_evt,
   input  logic             wdt_cfg_en,
   input  logic             lf_osc_rdy,
   input  logic             hf_rdy,
   output logic             lf_osc_en,
   output logic             upconv_en,
   output logic             cpu_clk_fast,
   output logic             cpu_clk_run,
   output logic             wdt_osc_en,
   output logic [1:0]       mode_state
);
   mode_bits_t bits;
   logic       halted, idle_exit, lf_wait;
   pmode_t     mode;

   pcc_mode_reg #(.REG_W(REG_W)) u_reg (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (reg_wr_en),
      .wr_data  (reg_wr_data),
      .clr_deep (idle_exit),
      .bits     (bits),
      .rd_data  (reg_rd_data)
   );

   pcc_halt_track u_halt (
      .clk        (clk),
      .rst_n      (rst_n),
      .halt_pulse (halt_pulse),
      .wake_evt   (wake_evt),
      .deep_sel   (bits.deep),
      .lf_rdy     (lf_osc_rdy),
      .halted     (halted),
      .idle_exit  (idle_exit),
      .lf_wait    (lf_wait)
   );

   pcc_mode_decode u_dec (
      .bits     (bits),
      .halted   (halted),
      .lf_wait  (lf_wait),
      .hf_rdy   (hf_rdy),
      .mode     (mode),
      .lf_en    (lf_osc_en),
      .up_en    (upconv_en),
      .sel_fast (cpu_clk_fast),
      .clk_run  (cpu_clk_run)
   );

   assign wdt_osc_en = wdt_cfg_en;
   assign mode_state = mode;
endmodule

// File: rtl/pwr_clk_ctrl_chk.sv
`timescale 1ns/1ps
module pwr_clk_ctrl_chk #(
   parameter int REG_W = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             reg_wr_en,
   input logic [REG_W-1:0] reg_wr_data,
   input logic [REG_W-1:0] reg_rd_data,
   input logic             halt_pulse,
   input logic             wake_evt,
   input logic             wdt_cfg_en,
   input logic             lf_osc_rdy,
   input logic             hf_rdy,
   input logic             lf_osc_en,
   input logic             upconv_en,
   input logic             cpu_clk_fast,
   input logic             cpu_clk_run,
   input logic             wdt_osc_en,
   input logic [1:0]       mode_state
);
   generate
      if (REG_W > 3) begin : g_unimpl
         a_r2_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
            reg_rd_data[REG_W-1:3] == '0);
      end
   endgenerate

   a_r4_fast_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
      cpu_clk_fast |-> (hf_rdy && upconv_en && mode_state == 2'd1));

   a_r6_sleep_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_state == 2'd2) |-> (lf_osc_en && !upconv_en && !cpu_clk_run));

   a_r7_idle_outputs: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_state == 2'd3) |-> (!lf_osc_en && !upconv_en && !cpu_clk_run));

   a_r8_halt_stops_cpu: assert property (@(posedge clk) disable iff (!rst_n)
      (halt_pulse && !wake_evt) |=> !cpu_clk_run);

   a_r9_idle_wake_clears: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_state == 2'd3 && wake_evt && !reg_wr_en) |=> (!reg_rd_data[1] && !cpu_clk_run));

   a_r10_wdt_follows_cfg: assert property (@(posedge clk) disable iff (!rst_n)
      wdt_osc_en == wdt_cfg_en);
endmodule

bind pwr_clk_ctrl pwr_clk_ctrl_chk #(.REG_W(REG_W)) u_chk (.*);

// File: tb/tb_pwr_clk_ctrl.sv
`timescale 1ns/1ps
module tb_pwr_clk_ctrl;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       reg_wr_en = 1'b0;
   logic [7:0] reg_wr_data = '0;
   logic [7:0] reg_rd_data;
   logic       halt_pulse = 1'b0;
   logic       wake_evt = 1'b0;
   logic       wdt_cfg_en = 1'b1;
   logic       lf_osc_rdy = 1'b1;
   logic       hf_rdy = 1'b0;
   logic       lf_osc_en, upconv_en, cpu_clk_fast, cpu_clk_run, wdt_osc_en;
   logic [1:0] mode_state;

   int n_chk = 0;
   int n_bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   pwr_clk_ctrl dut (
      .clk(clk), .rst_n(rst_n), .reg_wr_en(reg_wr_en), .reg_wr_data(reg_wr_data),
      .reg_rd_data(reg_rd_data), .halt_pulse(halt_pulse), .wake_evt(wake_evt),
      .wdt_cfg_en(wdt_cfg_en), .lf_osc_rdy(lf_osc_rdy), .hf_rdy(hf_rdy),
      .lf_osc_en(lf_osc_en), .upconv_en(upconv_en), .cpu_clk_fast(cpu_clk_fast),
      .cpu_clk_run(cpu_clk_run), .wdt_osc_en(wdt_osc_en), .mode_state(mode_state)
   );

   task automatic chk(input string req, input string what, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // outputs packed as {lf_osc_en, upconv_en, cpu_clk_fast, cpu_clk_run}
   function automatic int outs();
      return {lf_osc_en, upconv_en, cpu_clk_fast, cpu_clk_run};
   endfunction

   task automatic wr(input logic [7:0] d);
      @(negedge clk); reg_wr_en = 1'b1; reg_wr_data = d;
      @(negedge clk); reg_wr_en = 1'b0;
   endtask

   task automatic do_halt();
      @(negedge clk); halt_pulse = 1'b1;
      @(negedge clk); halt_pulse = 1'b0;
   endtask

   task automatic do_wake();
      @(negedge clk); wake_evt = 1'b1;
      @(negedge clk); wake_evt = 1'b0;
   endtask

   task automatic t_reset();
      chk("R1", "rd_data", reg_rd_data, 0);
      chk("R1", "mode", mode_state, 0);
      chk("R1", "outs", outs(), 4'b1001);
   endtask

   task automatic t_regs();
      wr(8'hFF);
      chk("R2", "rd_data all ones", reg_rd_data, 8'h07);
      wr(8'hA2);
      chk("R2", "rd_data A2", reg_rd_data, 8'h02);
      wr(8'h00);
   endtask

   task automatic t_normal();
      hf_rdy = 1'b0;
      wr(8'h05);
      chk("R3", "mode normal", mode_state, 1);
      chk("R4", "outs before ready", outs(), 4'b1101);
      @(negedge clk); hf_rdy = 1'b1;
      @(negedge clk);
      chk("R3", "outs fast", outs(), 4'b1111);
      wr(8'h04);
      chk("R4", "sel w/o upconv", outs(), 4'b1001);
      chk("R4", "mode green", mode_state, 0);
   endtask

   task automatic t_green();
      wr(8'h01);
      chk("R5", "mode", mode_state, 0);
      chk("R5", "outs up only", outs(), 4'b1101);
      wr(8'h02);
      chk("R5", "outs deep only", outs(), 4'b1001);
   endtask

   task automatic t_sleep();
      wr(8'h05);
      do_halt();
      chk("R6", "mode sleep", mode_state, 2);
      chk("R6", "outs", outs(), 4'b1000);
      chk("R10", "wdt in sleep", wdt_osc_en, 1);
      do_wake();
      chk("R8", "mode after wake", mode_state, 1);
      chk("R8", "outs after wake", outs(), 4'b1111);
   endtask

   task automatic t_idle();
      wr(8'h07);
      do_halt();
      chk("R7", "mode idle", mode_state, 3);
      chk("R7", "outs", outs(), 4'b0000);
      chk("R10", "wdt in idle", wdt_osc_en, 1);
      lf_osc_rdy = 1'b0;
      do_wake();
      chk("R9", "bit1 cleared", reg_rd_data, 8'h05);
      chk("R9", "gate held", cpu_clk_run, 0);
      chk("R9", "lf enabled", lf_osc_en, 1);
      @(negedge clk);
      chk("R9", "still held", cpu_clk_run, 0);
      lf_osc_rdy = 1'b1;
      @(negedge clk);
      chk("R9", "released", cpu_clk_run, 1);
      chk("R8", "mode normal", mode_state, 1);
   endtask

   task automatic t_wdt_off();
      wdt_cfg_en = 1'b0;
      @(negedge clk);
      chk("R10", "wdt off", wdt_osc_en, 0);
      wr(8'h02);
      do_halt();
      chk("R10", "wdt off idle", wdt_osc_en, 0);
      do_wake();
      wdt_cfg_en = 1'b1;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_regs();
      t_normal();
      t_green();
      t_sleep();
      t_idle();
      t_wdt_off();
      done = 1'b1;
   end

   initial begin
      for (int i = 0; i < 20000; i++) begin
         @(posedge clk);
         if (done) break;
      end
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: actual hung expected done");
      end
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
   end
endmodule